// File: doc/BRIEF.md
# Strided Vector Address Generator with Strip Mining

This block produces the stream of byte addresses that a vector load or store unit needs to walk a vector in memory. A single start pulse supplies four values: a base address, a signed stride counted in elements, an element size and a total element count. The block then issues one element address per handshake. Each address lies one stride, scaled to bytes, past the one before. The stride is added into a running accumulator, so no multiplier is needed.

Vectors longer than the hardware maximum length (parameter `MVL`) are split into strips. When the total count is not a whole multiple of `MVL`, the first strip holds the leftover `n mod MVL` elements. Every later strip holds exactly `MVL` elements. The address stream runs straight across strip boundaries. On the first address of each strip the block raises a strip marker, and the vector-length output shows that strip's length for the whole strip. When the last address has been accepted, a one-cycle done pulse follows.

The control is a three-state machine:
- `ST_IDLE`: waiting. A start pulse moves it to `ST_ISSUE`, or straight to `ST_DONE` when the count is zero.
- `ST_ISSUE`: offering addresses. It goes to `ST_DONE` on the handshake of the final element.
- `ST_DONE`: asserts done for one cycle, then always returns to `ST_IDLE`.

Top module: `vec_stride_agen`

## Requirements
- R1: After reset, `addr_valid`, `strip_first` and `done` are all low.
- R2: The first address issued equals `base_addr`. Each later address equals the previous one plus `stride` (a two's-complement element count) times the element byte size, wrapping modulo 2^ADDR_W.
- R3: `elem_sz` encodes the element byte size as 2^elem_sz. Codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and 3 is the 64-bit element.
- R4: The first strip's length is `n mod MVL` when that value is nonzero, and `MVL` otherwise. Every following strip has length `MVL`.
- R5: `strip_first` is high exactly on the first address of each strip. `vl` shows that strip's length on every address of the strip.
- R6: A start with `total_n` of zero issues no address and raises `done` in the cycle after start.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr`, `vl` and `strip_first` hold their values.
- R8: The cycle after start, the first address is offered. From then until the last element is accepted, `addr_valid` stays high, including across strip boundaries. Exactly `total_n` addresses are accepted.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the last element, and `addr_valid` is low while it is high.
- R10: A start pulse that arrives while addresses are being issued is ignored, and the current sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new vector walk (accepted only when idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | STRIDE_W | Signed distance between elements, in elements |
| elem_sz | input | 2 | Log2 of the element size in bytes |
| total_n | input | CNT_W | Total number of elements |
| addr | output | ADDR_W | Current element byte address |
| addr_valid | output | 1 | Address is offered |
| addr_ready | input | 1 | Consumer accepts the address |
| vl | output | LEN_W | Length of the strip the current address belongs to |
| strip_first | output | 1 | Current address opens a strip |
| done | output | 1 | One-cycle pulse after the final element is accepted |

## Verification
The bench builds the block with `MVL` set to 8 instead of 64 and keeps 32-bit addresses with a 16-bit stride. A short `MVL` lets a few dozen elements cover a leading remainder strip followed by several full strips, as well as a count that is an exact multiple of `MVL`, within a short run. The 32-bit address width lets a walk starting near the top of the address space check that wrap-around is modular. Negative strides and every element-size code are covered, and a stalling consumer is paired with a multi-strip walk so that holds can land on strip boundaries.

// File: rtl/vsag_pkg.sv
package vsag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } vsag_state_e;
endpackage

// File: rtl/vsag_fsm.sv
module vsag_fsm
    import vsag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        n_zero,
    input  logic        xfer,
    input  logic        last_elem,
    output vsag_state_e state,
    output logic        load,
    output logic        issuing,
    output logic        done
);
    vsag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = n_zero ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (xfer && last_elem) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        issuing = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  load    = start && !n_zero;
            ST_ISSUE: issuing = 1'b1;
            ST_DONE:  done    = 1'b1;
            default:  ;
        endcase
    end

    assign state = state_q;

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) && !(xfer && last_elem) |=> state_q == ST_ISSUE);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> state_q == ST_IDLE);
endmodule

// File: rtl/vsag_strip_ctl.sv
module vsag_strip_ctl #(
    parameter int MVL   = 64,
    parameter int CNT_W = 16,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] n_in,
    input  logic             xfer,
    output logic [LEN_W-1:0] vl,
    output logic             strip_open,
    output logic             last_elem
);
    localparam int              MVL_LG = (MVL > 1) ? $clog2(MVL) : 1;
    localparam logic [LEN_W-1:0] MVL_V  = LEN_W'(MVL);

    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] first_len;
    logic [CNT_W-1:0] remain_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] vl_q;
    logic             first_q;

    generate
        if ((MVL & (MVL - 1)) == 0) begin : g_pow2
            assign rem = LEN_W'(n_in[MVL_LG-1:0]);
        end else begin : g_modulo
            assign rem = LEN_W'(n_in % CNT_W'(MVL));
        end
    endgenerate

    assign first_len = (rem == '0) ? MVL_V : rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            left_q   <= '0;
            vl_q     <= '0;
            first_q  <= 1'b0;
        end else if (load) begin
            remain_q <= n_in;
            left_q   <= first_len;
            vl_q     <= first_len;
            first_q  <= 1'b1;
        end else if (xfer) begin
            remain_q <= remain_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
                left_q  <= MVL_V;
                vl_q    <= MVL_V;
                first_q <= 1'b1;
            end else begin
                left_q  <= left_q - 1'b1;
                first_q <= 1'b0;
            end
        end
    end

    assign vl         = vl_q;
    assign strip_open = first_q;
    assign last_elem  = (remain_q == CNT_W'(1));

    // R4
    vl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (vl_q != '0) && (vl_q <= MVL_V) && first_q);

    // R5
    strip_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !load && (left_q == LEN_W'(1)) && (remain_q > CNT_W'(1))
        |=> first_q && (vl_q == MVL_V) && (left_q == MVL_V));
endmodule

// File: rtl/vsag_addr_acc.sv
module vsag_addr_acc #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]          esz,
    input  logic                xfer,
    output logic [ADDR_W-1:0]   addr
);
    localparam int EXT_W = ADDR_W - STRIDE_W;

    logic [ADDR_W-1:0] stride_ext;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] addr_q;

    assign stride_ext = {{EXT_W{stride[STRIDE_W-1]}}, stride};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            step_q <= stride_ext << esz;
            addr_q <= base;
        end else if (xfer) begin
            addr_q <= addr_q + step_q;
        end
    end

    assign addr = addr_q;

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !load |=> addr_q == $past(addr_q) + $past(step_q));
endmodule

// File: rtl/vec_stride_agen.sv
module vec_stride_agen
    import vsag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int CNT_W    = 16,
    parameter int MVL      = 64,
    parameter int LEN_W    = $clog2(MVL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]          elem_sz,
    input  logic [CNT_W-1:0]    total_n,
    output logic [ADDR_W-1:0]   addr,
    output logic                addr_valid,
    input  logic                addr_ready,
    output logic [LEN_W-1:0]    vl,
    output logic                strip_first,
    output logic                done
);
    vsag_state_e state;
    logic        load, issuing, xfer, last_elem, strip_open;

    assign xfer = issuing && addr_ready;

    vsag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .n_zero    (total_n == '0),
        .xfer      (xfer),
        .last_elem (last_elem),
        .state     (state),
        .load      (load),
        .issuing   (issuing),
        .done      (done)
    );

    vsag_strip_ctl #(.MVL(MVL), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_strip (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .n_in       (total_n),
        .xfer       (xfer),
        .vl         (vl),
        .strip_open (strip_open),
        .last_elem  (last_elem)
    );

    vsag_addr_acc #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .base   (base_addr),
        .stride (stride),
        .esz    (elem_sz),
        .xfer   (xfer),
        .addr   (addr)
    );

    assign addr_valid  = issuing;
    assign strip_first = issuing && strip_open;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(vl) && $stable(strip_first));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);

    // R6
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && start && (total_n == '0) |=> done && !addr_valid);

    // R8
    first_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && start && (total_n != '0) |=> addr_valid && strip_first);
endmodule

// File: tb/vec_stride_agen_tb_top.sv
module vec_stride_agen_tb_top;
    localparam int ADDR_W = 32;
    localparam int STRIDE_W = 16;
    localparam int CNT_W = 16;
    localparam int MVL = 8;
    localparam int LEN_W = $clog2(MVL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [STRIDE_W-1:0] stride = '0;
    logic [1:0] elem_sz = '0;
    logic [CNT_W-1:0] total_n = '0;
    logic [ADDR_W-1:0] addr;
    logic addr_valid;
    logic addr_ready = 1'b1;
    logic [LEN_W-1:0] vl;
    logic strip_first;
    logic done;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vec_stride_agen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .CNT_W(CNT_W), .MVL(MVL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .stride(stride),
        .elem_sz(elem_sz), .total_n(total_n), .addr(addr), .addr_valid(addr_valid),
        .addr_ready(addr_ready), .vl(vl), .strip_first(strip_first), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // rmode 0: ready always high; 1: ready low every third cycle. poke: cycle of a stray start (0 = none)
    task automatic run_case(input string name, input logic [31:0] b, input int st, input logic [1:0] es,
                            input int n, input int rmode, input int poke);
        int idx = 0;
        int cyc = 0;
        bit fin = 0;
        bit prev_stall = 0;
        logic [31:0] prev_addr = '0;
        int first_len;
        first_len = (n % MVL == 0) ? MVL : n % MVL;
        @(negedge clk);
        base_addr = b; stride = STRIDE_W'(st); elem_sz = es; total_n = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 4000) begin
            if (done) begin
                chk(addr_valid == 1'b0, (n == 0) ? "R6" : "R9", {name, " valid with done"}, addr_valid, 0);
                chk(idx == n, (n == 0) ? "R6" : "R8", {name, " accepted count"}, idx, n);
                fin = 1;
            end else if (addr_valid) begin
                logic [31:0] ea;
                int evl;
                bit efirst;
                ea = b + (32'(st * idx) << es);
                if (idx < first_len) begin
                    evl = first_len; efirst = (idx == 0);
                end else begin
                    evl = MVL; efirst = ((idx - first_len) % MVL == 0);
                end
                chk(addr == ea, (poke != 0) ? "R10" : ((es != 2'd3) ? "R3" : "R2"), {name, " addr"}, addr, ea);
                chk(vl == LEN_W'(evl), "R4", {name, " vl"}, vl, evl);
                chk(strip_first == efirst, "R5", {name, " strip_first"}, strip_first, efirst);
                if (prev_stall) chk(addr == prev_addr, "R7", {name, " stall hold"}, addr, prev_addr);
            end else begin
                chk(1'b0, "R8", {name, " gap in issue"}, 0, 1);
            end
            if (!fin) begin
                start = (poke != 0 && cyc == poke);
                if (start) begin base_addr = 32'hDEAD_0000; total_n = 16'd3; end
                addr_ready = (rmode == 0) ? 1'b1 : (cyc % 3 != 1);
                prev_stall = addr_valid && !addr_ready;
                prev_addr = addr;
                if (addr_valid && addr_ready) idx++;
                cyc++;
                @(negedge clk);
            end
        end
        if (!fin) chk(1'b0, "R8", {name, " no done"}, 0, 1);
        start = 1'b0;
        addr_ready = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && addr_valid == 1'b0, "R9", {name, " done one cycle"}, done, 0);
    endtask

    task automatic t_reset;
        chk(addr_valid == 1'b0, "R1", "reset valid", addr_valid, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(strip_first == 1'b0, "R1", "reset strip_first", strip_first, 0);
    endtask

    task automatic t_short_contig;   run_case("short_contig", 32'h0000_1000, 1, 2'd3, 5, 0, 0); endtask
    task automatic t_remainder;      run_case("remainder", 32'h0004_0000, 3, 2'd3, 20, 0, 0); endtask
    task automatic t_exact_multiple; run_case("exact_mult", 32'h0000_8000, 1, 2'd3, 16, 0, 0); endtask
    task automatic t_empty;          run_case("empty", 32'h0000_2000, 1, 2'd3, 0, 0, 0); endtask
    task automatic t_neg_stall;      run_case("neg_stall", 32'h0001_0000, -2, 2'd2, 19, 1, 0); endtask
    task automatic t_byte_wrap;      run_case("byte_wrap", 32'hFFFF_FFF8, 5, 2'd0, 9, 0, 0); endtask
    task automatic t_half_stall;     run_case("half_stall", 32'h0000_0100, 7, 2'd1, 8, 1, 0); endtask
    task automatic t_busy_start;     run_case("busy_start", 32'h0000_3000, 2, 2'd3, 12, 0, 4); endtask

    initial begin
        #200000;
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_contig();
        t_remainder();
        t_exact_multiple();
        t_empty();
        t_neg_stall();
        t_byte_wrap();
        t_half_stall();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule